// File: doc/BRIEF.md
# Stride and Next-Line Prefetch Selector

This block sits beside a miss-history table in a memory-side prefetcher. For each miss request it receives the request address, the number of offsets recorded so far in the request's history entry, and the four newest of those offsets. It decides which low-cost prediction rule fits that history and produces at most one prefetch address per request. The rules are: fetch the next page, repeat a constant stride, or extend a stride that grows by a fixed amount each step.

When the history is long enough to judge but fits none of the rules, the block raises an irregular flag instead of a prefetch. A separate learning predictor can then take the request. Results are registered and appear one clock after the request.

Top module: `pf_sel_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pf_valid`, `pf_irregular` and `pf_mode` are all 0.
- R2: Every output reflects the request of the previous cycle. `pf_valid` is high exactly one cycle after an accepted request whose selected mode is not 0. Mode encoding: 0 none, 1 next page, 2 constant stride, 3 growing stride.
- R3: With `hist_cnt` below 3, no pattern check is made and the result is mode 1. The address is `req_addr` with its low 12 bits cleared, plus 4096.
- R4: With `hist_cnt` equal to 3, only `hist_off1`..`hist_off3` are used, and `hist_off3` is the newest. If `off3-off2` equals `off2-off1` and is non-zero, the result is mode 2 with address `req_addr + (off3-off2)`.
- R5: With `hist_cnt` above 3, if all three deltas `off1-off0`, `off2-off1` and `off3-off2` are equal and non-zero, the result is mode 2 with address `req_addr` plus the newest delta. This rule takes priority over R6.
- R6: With `hist_cnt` above 3, if the deltas are not all equal but the two second differences are equal, the result is mode 3. The address is `req_addr` plus the newest delta plus that second difference, provided this step is non-zero.
- R7: When the history is judged (count 3 or more) and no stride rule matches, `pf_irregular` is 1, `pf_valid` is 0 and `pf_mode` is 0.
- R8: A matching rule whose step is zero issues nothing: `pf_valid`, `pf_irregular` and `pf_mode` are all 0.
- R9: Deltas are signed and one bit wider than the 18-bit offsets. Negative steps and steps that cross the top of the address space wrap modulo 2^46.
- R10: A cycle with `req_valid` low produces `pf_valid=0`, `pf_irregular=0` and `pf_mode=0` in the next cycle.
- R11: With `hist_cnt` equal to 3, the value on `hist_off0` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present this cycle |
| req_addr | input | 46 | Miss physical address |
| hist_cnt | input | 9 | Offsets recorded in the history entry |
| hist_off0 | input | 18 | Oldest of the four newest offsets |
| hist_off1 | input | 18 | Second oldest offset |
| hist_off2 | input | 18 | Second newest offset |
| hist_off3 | input | 18 | Newest offset |
| pf_valid | output | 1 | Prefetch address is valid |
| pf_addr | output | 46 | Prefetch address |
| pf_mode | output | 2 | Selected rule (0 none, 1 next page, 2 stride, 3 growing) |
| pf_irregular | output | 1 | No simple rule fits; hand to learning engine |

## Verification
The assertions check the timing and exclusivity properties on every cycle:
- outputs depend only on the previous cycle's request;
- a valid prefetch never coincides with the irregular flag;
- next-page results are page aligned and come only from short histories;
- stride modes appear only when the history holds three or more offsets.

The exact predicted addresses can only be shown by the bench's scenarios. These cover positive, negative and wrapping steps, zero-step suppression, the priority of constant stride over growing stride, and the indifference to the oldest offset when the count is three.

// File: rtl/pf_sel_pkg.sv
package pf_sel_pkg;

  typedef enum logic [1:0] {
    PF_NONE   = 2'd0,
    PF_NEXT   = 2'd1,
    PF_STRIDE = 2'd2,
    PF_GROW   = 2'd3
  } pf_mode_e;

  localparam int unsigned N_OFFS = 4;

endpackage

// File: rtl/pf_delta_unit.sv
module pf_delta_unit #(
  parameter int unsigned OFF_W = 18,
  parameter int unsigned N_OFF = 4,
  localparam int unsigned DW   = OFF_W + 1,
  localparam int unsigned DDW  = OFF_W + 2
) (
  input  logic [N_OFF-1:0][OFF_W-1:0] offs,
  output logic [N_OFF-2:0][DW-1:0]    deltas,
  output logic [N_OFF-3:0][DDW-1:0]   second_diff
);

  // first differences between neighbouring offsets, index 0 oldest
  for (genvar i = 0; i < N_OFF - 1; i++) begin : g_delta
    always_comb begin
      deltas[i] = DW'({1'b0, offs[i+1]}) - DW'({1'b0, offs[i]});
    end
  end

  // second differences between neighbouring deltas, sign extended
  for (genvar j = 0; j < N_OFF - 2; j++) begin : g_dd
    always_comb begin
      second_diff[j] = {deltas[j+1][DW-1], deltas[j+1]}
                     - {deltas[j][DW-1], deltas[j]};
    end
  end

endmodule

// File: rtl/pf_rule_select.sv
module pf_rule_select
  import pf_sel_pkg::*;
#(
  parameter int unsigned ADDR_W     = 46,
  parameter int unsigned OFF_W      = 18,
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned DW        = OFF_W + 1,
  localparam int unsigned DDW       = OFF_W + 2,
  localparam int unsigned SW        = OFF_W + 3,
  localparam int unsigned PN_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [CNT_W-1:0]      hist_cnt,
  input  logic [2:0][DW-1:0]    deltas,
  input  logic [1:0][DDW-1:0]   second_diff,
  output pf_mode_e              sel_mode,
  output logic                  sel_irregular,
  output logic [ADDR_W-1:0]     sel_addr
);

  logic            short_hist, three_hist;
  logic            eq_new, eq_old, dd_eq;
  logic [SW-1:0]   stride_step, grow_step, step;
  logic [ADDR_W-1:0] step_ext;
  logic [PN_W-1:0] next_page;

  assign short_hist = (hist_cnt < CNT_W'(3));
  assign three_hist = (hist_cnt == CNT_W'(3));
  assign eq_new     = (deltas[2] == deltas[1]);
  assign eq_old     = (deltas[1] == deltas[0]);
  assign dd_eq      = (second_diff[1] == second_diff[0]);

  assign stride_step = {{(SW-DW){deltas[2][DW-1]}}, deltas[2]};
  assign grow_step   = stride_step + {{(SW-DDW){second_diff[1][DDW-1]}}, second_diff[1]};

  assign next_page   = req_addr[ADDR_W-1:PAGE_SHIFT] + PN_W'(1);

  always_comb begin
    sel_mode      = PF_NONE;
    sel_irregular = 1'b0;
    step          = '0;
    if (short_hist) begin
      sel_mode = PF_NEXT;
    end else if (three_hist) begin
      if (eq_new) begin
        step     = stride_step;
        sel_mode = (stride_step != '0) ? PF_STRIDE : PF_NONE;
      end else begin
        sel_irregular = 1'b1;
      end
    end else begin
      if (eq_new && eq_old) begin
        step     = stride_step;
        sel_mode = (stride_step != '0) ? PF_STRIDE : PF_NONE;
      end else if (dd_eq) begin
        step     = grow_step;
        sel_mode = (grow_step != '0) ? PF_GROW : PF_NONE;
      end else begin
        sel_irregular = 1'b1;
      end
    end
  end

  assign step_ext = {{(ADDR_W-SW){step[SW-1]}}, step};

  always_comb begin
    if (sel_mode == PF_NEXT) sel_addr = {next_page, PAGE_SHIFT'(0)};
    else                     sel_addr = req_addr + step_ext;
  end

endmodule

// File: rtl/pf_out_stage.sv
module pf_out_stage
  import pf_sel_pkg::*;
#(
  parameter int unsigned ADDR_W = 46
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_req,
  input  pf_mode_e          in_mode,
  input  logic              in_irregular,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [1:0]        out_mode,
  output logic              out_irregular,
  output logic [ADDR_W-1:0] out_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_mode      <= 2'd0;
      out_irregular <= 1'b0;
      out_addr      <= '0;
    end else begin
      out_valid     <= in_req && (in_mode != PF_NONE);
      out_mode      <= in_req ? in_mode : PF_NONE;
      out_irregular <= in_req && in_irregular;
      if (in_req && (in_mode != PF_NONE)) out_addr <= in_addr;
    end
  end

  // R7: a prefetch and the irregular hand-off are never issued together
  p_valid_not_irr_r7: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_irregular));

  // R7: irregular results carry no mode
  p_irr_no_mode_r7: assert property (@(posedge clk) disable iff (rst)
    out_irregular |-> (out_mode == 2'd0));

  // R2: a valid prefetch needs a request one cycle earlier
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_req));

endmodule

// File: rtl/pf_sel_top.sv
module pf_sel_top
  import pf_sel_pkg::*;
#(
  parameter int unsigned ADDR_W     = 46,
  parameter int unsigned OFF_W      = 18,
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned DW        = OFF_W + 1,
  localparam int unsigned DDW       = OFF_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  hist_cnt,
  input  logic [OFF_W-1:0]  hist_off0,
  input  logic [OFF_W-1:0]  hist_off1,
  input  logic [OFF_W-1:0]  hist_off2,
  input  logic [OFF_W-1:0]  hist_off3,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [1:0]        pf_mode,
  output logic              pf_irregular
);

  logic [N_OFFS-1:0][OFF_W-1:0] offs;
  logic [N_OFFS-2:0][DW-1:0]    deltas;
  logic [N_OFFS-3:0][DDW-1:0]   second_diff;
  pf_mode_e                     sel_mode;
  logic                         sel_irregular;
  logic [ADDR_W-1:0]            sel_addr;

  assign offs = {hist_off3, hist_off2, hist_off1, hist_off0};

  pf_delta_unit #(
    .OFF_W (OFF_W),
    .N_OFF (N_OFFS)
  ) u_delta (
    .offs        (offs),
    .deltas      (deltas),
    .second_diff (second_diff)
  );

  pf_rule_select #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .CNT_W      (CNT_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_rule (
    .req_addr      (req_addr),
    .hist_cnt      (hist_cnt),
    .deltas        (deltas),
    .second_diff   (second_diff),
    .sel_mode      (sel_mode),
    .sel_irregular (sel_irregular),
    .sel_addr      (sel_addr)
  );

  pf_out_stage #(
    .ADDR_W (ADDR_W)
  ) u_out (
    .clk           (clk),
    .rst           (rst),
    .in_req        (req_valid),
    .in_mode       (sel_mode),
    .in_irregular  (sel_irregular),
    .in_addr       (sel_addr),
    .out_valid     (pf_valid),
    .out_mode      (pf_mode),
    .out_irregular (pf_irregular),
    .out_addr      (pf_addr)
  );

  // R10: an idle cycle leaves nothing behind
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!pf_valid && !pf_irregular && pf_mode == 2'd0));

  // R3: next-page results are page aligned and come from short histories
  p_next_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_mode == 2'd1) |->
      (pf_addr[PAGE_SHIFT-1:0] == '0 && $past(hist_cnt) < CNT_W'(3)));

  // R4: stride modes need at least three recorded offsets
  p_stride_needs_hist_r4: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_mode[1]) |-> ($past(hist_cnt) >= CNT_W'(3)));

  // R2: a valid result always carries a non-zero mode
  p_valid_has_mode_r2: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_mode != 2'd0));

endmodule

// File: tb/pf_sel_top_tb.sv
module pf_sel_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 46;
  localparam int OW = 18;
  localparam int CW = 9;

  typedef struct {
    logic          v;
    logic [AW-1:0] a;
    logic [1:0]    m;
    logic          irr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] hist_cnt = '0;
  logic [OW-1:0] o0 = '0, o1 = '0, o2 = '0, o3 = '0;
  logic          pf_valid;
  logic [AW-1:0] pf_addr;
  logic [1:0]    pf_mode;
  logic          pf_irregular;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_sel_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .hist_cnt(hist_cnt), .hist_off0(o0), .hist_off1(o1), .hist_off2(o2),
    .hist_off3(o3), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .pf_mode(pf_mode), .pf_irregular(pf_irregular)
  );

  function automatic exp_t model(input logic vld, input logic [AW-1:0] a,
                                 input int cnt, input int x0, input int x1,
                                 input int x2, input int x3, input string tag);
    exp_t e;
    longint d0, d1, d2, s;
    e.v = 0; e.a = '0; e.m = 2'd0; e.irr = 0; e.tag = tag;
    if (!vld) return e;
    d0 = longint'(x1 - x0); d1 = longint'(x2 - x1); d2 = longint'(x3 - x2);
    if (cnt < 3) begin
      e.v = 1; e.m = 2'd1; e.a = (a & ~AW'(12'hFFF)) + AW'(4096);
    end else if (cnt == 3) begin
      if (d2 == d1) begin
        if (d2 != 0) begin e.v = 1; e.m = 2'd2; e.a = a + AW'(d2); end
      end else e.irr = 1;
    end else begin
      if (d2 == d1 && d1 == d0) begin
        if (d2 != 0) begin e.v = 1; e.m = 2'd2; e.a = a + AW'(d2); end
      end else if ((d2 - d1) == (d1 - d0)) begin
        s = d2 + (d2 - d1);
        if (s != 0) begin e.v = 1; e.m = 2'd3; e.a = a + AW'(s); end
      end else e.irr = 1;
    end
    return e;
  endfunction

  task automatic issue(input logic [AW-1:0] a, input int cnt, input int x0,
                       input int x1, input int x2, input int x3, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; hist_cnt = CW'(cnt);
    o0 = OW'(x0); o1 = OW'(x1); o2 = OW'(x2); o3 = OW'(x3);
    q.push_back(model(1'b1, a, cnt, x0, x1, x2, x3, tag));
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = 46'h3FFF_FFFF_FFFF; hist_cnt = CW'(1);
    q.push_back(model(1'b0, '0, 0, 0, 0, 0, 0, tag));
  endtask

  // monitor: compare each result against the queue head
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (pf_valid !== e.v || pf_mode !== e.m || pf_irregular !== e.irr ||
          (e.v && pf_addr !== e.a)) begin
        n_fail++;
        $display("FAIL %s: got v=%0b m=%0d irr=%0b a=%h, exp v=%0b m=%0d irr=%0b a=%h",
                 e.tag, pf_valid, pf_mode, pf_irregular, pf_addr,
                 e.v, e.m, e.irr, e.a);
      end
    end
  end

  task automatic check_quiet(input string tag);
    n_tests++;
    if (pf_valid !== 1'b0 || pf_irregular !== 1'b0 || pf_mode !== 2'd0) begin
      n_fail++;
      $display("FAIL %s: got v=%0b m=%0d irr=%0b, exp all zero",
               tag, pf_valid, pf_mode, pf_irregular);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a request pending during reset
    req_valid = 1'b1; hist_cnt = CW'(0);
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1 after reset");

    issue(46'h0000_1234_5678, 0, 0, 0, 0, 0, "R3 cnt0");
    issue(46'h0000_0000_0FFF, 2, 0, 0, 0, 0, "R3 cnt2 edge");
    issue(46'h3FFF_FFFF_F800, 1, 0, 0, 0, 0, "R3 top wrap R9");
    issue(46'h0000_0010_0000, 3, 7, 10, 20, 30, "R4 stride");
    issue(46'h0000_0010_0000, 3, 99999, 10, 20, 30, "R11 off0 ignored");
    issue(46'h0000_0010_0000, 3, 0, 10, 20, 35, "R7 cnt3 irregular");
    issue(46'h0000_0020_0000, 3, 1, 5, 5, 5, "R8 cnt3 zero");
    idle("R10 idle");
    issue(46'h0000_0030_0000, 5, 0, 4, 8, 12, "R5 stride");
    issue(46'h0000_0030_0000, 4, 100, 90, 80, 70, "R9 negative stride");
    issue(46'h0000_0000_0004, 4, 30, 20, 10, 0, "R9 addr wrap");
    issue(46'h0000_0040_0000, 4, 0, 1, 3, 6, "R6 growing");
    issue(46'h0000_0040_0000, 4, 100, 90, 70, 40, "R6 growing negative");
    issue(46'h0000_0050_0000, 4, 0, 5, 7, 20, "R7 cnt4 irregular");
    issue(46'h0000_0050_0000, 4, 7, 7, 7, 7, "R8 cnt4 zero");
    issue(46'h0000_0050_0000, 4, 0, 3, 5, 6, "R8 growing zero step");
    issue(46'h0000_0060_0000, 4, 262140, 262142, 262144, 2, "R9 offset wrap");
    issue(46'h0000_0060_0000, 200, 10, 20, 30, 40, "R5 priority over R6");
    idle("R10 idle after burst");
    idle("R2 second idle");
    issue(46'h0000_0070_0123, 2, 5, 6, 7, 8, "R2 back to back");
    idle("R10 final");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule